// File: doc/BRIEF.md
# Signed Agreement Sum of Two One-Bit-Coded Vectors

This block compares two equal-width vectors whose bits each stand for a sign: a bit of 1 means +1 and a bit of 0 means -1. For each lane it forms the product of the two signs. A lane where the bits agree gives +1, and a lane where they differ gives -1. The block returns the signed total of these products, which is the number of agreeing lanes minus the number of disagreeing lanes. A correlator built from many such units slides one-bit-coded data past a one-bit-coded reference and calls this block once per alignment.

The lanes first pass through one XNOR gate each. The lanes are then cut into L equal groups. Each group's bit pattern addresses a small read-only table, filled at elaboration time, that holds the group's signed score. An adder stage combines the group scores. A register stands after each of the three stages, so the block accepts one vector pair on every clock. The result appears a fixed three cycles later, with a valid flag carried alongside it.

Top module: `sign_agree_sum`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `sum` are 0 after that edge. A pair accepted before the reset does not emerge afterwards.
- R2: For each accepted pair, `sum` equals the count of lane positions where `a_bits` and `b_bits` hold the same bit, minus the count where they differ.
- R3: `sum` is a two's complement value of $clog2(W)+2 bits and represents both +W (all lanes agree) and -W (all lanes differ) exactly.
- R4: A pair presented with `in_valid` high at rising edge n gives `out_valid` high and its `sum` right after rising edge n+2. Otherwise `out_valid` is low in that cycle.
- R5: Pairs presented on consecutive cycles give results on consecutive cycles, in the same order, with no bubbles.
- R6: A cycle with `in_valid` low produces no result: three cycles later `out_valid` is low and `sum` keeps its previous value, whatever `a_bits` and `b_bits` held.
- R7: Lanes on either side of a group boundary (for example bits 7 and 8 with the default of 8 lanes per group) each count exactly once.
- R8: Every valid `sum` has the same parity as W and lies in the range -W to +W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The vector pair on `a_bits`/`b_bits` is to be processed |
| a_bits | input | W | First sign vector, bit 1 = +1, bit 0 = -1 |
| b_bits | input | W | Second sign vector, same encoding |
| out_valid | output | 1 | `sum` holds a new result |
| sum | output | $clog2(W)+2 | Signed agreement total, two's complement |

## Verification
The bench drives the two extremes, +W and -W. A sum that is one bit too narrow wraps at these values, and an inverted product bit swaps their signs. It drives single and paired disagreements at the ends of the vector and across a group boundary, where a table filled with an off-by-one score or a miswired group slice gives a total that is wrong by two or more. It also drives back-to-back pairs interleaved with idle cycles carrying junk data, and sends a reset while a pair is still in flight. A valid flag that is delayed wrongly, or a result register that loads on idle cycles, shows up there as a missing result, an early result or a changed sum.

// File: rtl/sas_pkg.sv
package sas_pkg;

  // Signed score of one group: agreeing lanes count +1, differing lanes -1.
  // The pattern bits are the per-lane XNOR results (1 = agreement).
  function automatic int group_score(input int pattern, input int lanes);
    int ones;
    ones = 0;
    for (int i = 0; i < lanes; i++) begin
      if (((pattern >> i) & 1) == 1) ones++;
    end
    return 2 * ones - lanes;
  endfunction

endpackage

// File: rtl/sas_xnor_stage.sv
module sas_xnor_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] agree_o
);

  always_ff @(posedge clk) begin
    agree_o <= ~(a_i ^ b_i);
    if (rst) valid_o <= 1'b0;
    else     valid_o <= valid_i;
  end

endmodule

// File: rtl/sas_group_rom.sv
module sas_group_rom #(
  parameter int G  = 8,
  parameter int GW = $clog2(G) + 2
) (
  input  logic                 clk,
  input  logic [G-1:0]         addr_i,
  output logic signed [GW-1:0] score_o
);

  localparam int DEPTH = 1 << G;

  logic signed [GW-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = GW'(sas_pkg::group_score(i, G));
    end
  end

  // Registered read without reset so the table maps onto block RAM.
  always_ff @(posedge clk) begin
    score_o <= rom[addr_i];
  end

endmodule

// File: rtl/sas_adder_tree.sv
module sas_adder_tree #(
  parameter int L  = 4,
  parameter int GW = 5,
  parameter int SW = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic signed [GW-1:0] score_i [L],
  output logic                 valid_o,
  output logic signed [SW-1:0] sum_o
);

  logic signed [SW-1:0] total;

  always_comb begin
    total = '0;
    for (int g = 0; g < L; g++) begin
      total = total + SW'(score_i[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sum_o <= total;
    end
  end

endmodule

// File: rtl/sign_agree_sum.sv
module sign_agree_sum #(
  parameter int W = 32,
  parameter int L = 4,
  localparam int SW = $clog2(W) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [W-1:0]         a_bits,
  input  logic [W-1:0]         b_bits,
  output logic                 out_valid,
  output logic signed [SW-1:0] sum
);

  localparam int G  = W / L;
  localparam int GW = $clog2(G) + 2;

  logic         agree_valid;
  logic [W-1:0] agree;
  logic         score_valid;
  logic signed [GW-1:0] score [L];

  sas_xnor_stage #(.W(W)) u_xnor (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .a_i     (a_bits),
    .b_i     (b_bits),
    .valid_o (agree_valid),
    .agree_o (agree)
  );

  for (genvar g = 0; g < L; g++) begin : g_group
    sas_group_rom #(.G(G), .GW(GW)) u_rom (
      .clk     (clk),
      .addr_i  (agree[g*G +: G]),
      .score_o (score[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) score_valid <= 1'b0;
    else     score_valid <= agree_valid;
  end

  sas_adder_tree #(.L(L), .GW(GW), .SW(SW)) u_add (
    .clk     (clk),
    .rst     (rst),
    .valid_i (score_valid),
    .score_i (score),
    .valid_o (out_valid),
    .sum_o   (sum)
  );

endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
  parameter int W  = 32,
  parameter int SW = $clog2(W) + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [SW-1:0] sum
);

  logic [1:0] settle;

  always_ff @(posedge clk) begin
    if (rst)                settle <= 2'd0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  // R1: reset clears the result registers
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && sum == '0));

  // R4: fixed three-cycle latency of the valid flag
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R6: idle slots leave the result untouched
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (settle != 2'd0 && !out_valid) |-> $stable(sum));

  // R8: result range
  a_r8_bounded: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sum <= W && sum >= -W));

  // R8: result parity follows W
  a_r8_parity: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sum[0] == W[0]));

endmodule

bind sign_agree_sum sas_checker #(.W(W)) u_sas_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .sum       (sum)
);

// File: tb/tb_sign_agree_sum.sv
`timescale 1ns/1ps
module tb_sign_agree_sum;

  localparam int W   = 32;
  localparam int SW  = $clog2(W) + 2;
  localparam int LAT = 3;
  localparam int NT  = 14;
  localparam int MAXQ = 256;

  // stimulus a, stimulus b, expected sum, requirement tag
  localparam logic [W-1:0] TA [NT] = '{
    32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'hAAAAAAAA, 32'hAAAAAAAA,
    32'h0000FFFF, 32'h00000001, 32'h80000000, 32'h000000FF, 32'h01010101,
    32'hFFFFFFFE, 32'h12345678, 32'h0F0F0F0F, 32'h00000180};
  localparam logic [W-1:0] TB [NT] = '{
    32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h55555555, 32'hAAAAAAAA,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000,
    32'h00000000, 32'h12345678, 32'h00FF00FF, 32'h00000000};
  localparam int TE [NT] = '{
    32, 32, -32, -32, 32, 0, 30, 30, 16, 24, -30, 32, 0, 28};
  localparam string TG [NT] = '{
    "R3", "R3", "R3", "R3", "R2", "R2", "R2", "R2", "R7", "R7",
    "R2", "R2", "R7", "R7"};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic [W-1:0]         a_bits = '0;
  logic [W-1:0]         b_bits = '0;
  logic                 out_valid;
  logic signed [SW-1:0] sum;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    n_iss = 0;
  int    rd = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  int    exp_q [MAXQ];
  int    cyc_q [MAXQ];
  string tag_q [MAXQ];
  int    last_sum = 0;
  logic [31:0] lfsr = 32'h1ACE5EED;

  sign_agree_sum #(.W(W), .L(4)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_bits(a_bits), .b_bits(b_bits), .out_valid(out_valid), .sum(sum)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    int s;
    s = 0;
    for (int i = 0; i < W; i++) s += (a[i] == b[i]) ? 1 : -1;
    return s;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input bit v, input string tg);
    @(negedge clk);
    a_bits = a;
    b_bits = b;
    in_valid = v;
    if (v) begin
      exp_q[n_iss] = ref_sum(a, b);
      cyc_q[n_iss] = cyc;
      tag_q[n_iss] = tg;
      n_iss++;
    end
  endtask

  // Output monitor: compares each result in order, its timing, and idle holds.
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (rd < n_iss) begin
          check(sum == exp_q[rd], tag_q[rd], int'(sum), exp_q[rd]);
          check(cyc == cyc_q[rd] + LAT, "R4 latency", cyc - cyc_q[rd], LAT);
          rd++;
        end else begin
          check(1'b0, "R6 spurious valid", 1, 0);
        end
        last_sum = int'(sum);
      end else begin
        if (rd < n_iss && cyc_q[rd] + LAT == cyc)
          check(1'b0, "R5 missing result", 0, 1);
        check(int'(sum) == last_sum, "R6 hold", int'(sum), last_sum);
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    check(sum == '0, "R1 sum", int'(sum), 0);
    rst = 1'b0;
    mon_en = 1'b1;

    // Table walk, back to back (R2, R3, R5, R7)
    for (int i = 0; i < NT; i++) issue(TA[i], TB[i], 1'b1, TG[i]);

    // Idle cycles carrying junk data (R6)
    for (int i = 0; i < 5; i++) issue(32'hDEADBEEF + i, 32'h0, 1'b0, "R6");

    // Mixed random stream with idle gaps (R2, R5, R6)
    for (int i = 0; i < 120; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      lfsr = next_rand(lfsr);
      ra = lfsr;
      lfsr = next_rand(lfsr);
      rb = lfsr;
      if (i % 3 == 0) rb = ra ^ (32'h1 << (i % W));
      issue(ra, rb, (i % 7) != 6, "R2");
    end
    issue('0, '0, 1'b0, "R6");
    repeat (LAT + 2) @(negedge clk);
    check(rd == n_iss, "R5 all results", rd, n_iss);

    // Reset while a pair is in flight (R1)
    mon_en = 1'b0;
    issue(32'hFFFFFFFF, 32'h0, 1'b1, "R1");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 flush valid", int'(out_valid), 0);
    check(sum == '0, "R1 flush sum", int'(sum), 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 no late result", int'(out_valid), 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule